// File: doc/BRIEF.md
# Narrow-to-wide indirect register bridge

This block lets a 32-bit host register bus reach a bank of 64-bit registers that sit inside a downstream engine. The host never addresses the wide registers directly. It stages a 64-bit value in two 32-bit data words, then writes a command word. The top bit of the command word selects the direction, and its low bits select the engine register. That single command write launches exactly one downstream access over a valid/ready request port. The access completes with a response that may carry an error.

For a write, the staged words form the outgoing 64-bit value. For a read, the fetched value replaces the staged words when the response arrives, and the host then reads it back as two halves. An aggregate error flag and a busy flag in the status word tell the host when an access has finished and whether it went wrong. A write to the reset register clears the error and drops an access that is still in flight. An interrupt register enables an interrupt output that follows the error flag.

The downstream address is formed as a fixed window base of 0x70000, plus a per-instance offset parameter, plus the register index taken from the command.

Top module: `b64_bridge`

## Requirements
- R1: After reset, the status word, both data words and the interrupt enable read as zero, no downstream request is raised, and `irq_o` is low.
- R2: The host register offsets are fixed: high data word (bits 63:32) at 0x00, low data word (bits 31:0) at 0x04, command at 0x08, reset at 0x18, status at 0x1C, interrupt enable at 0x20. Reads of the command, reset and unmapped offsets return zero. When idle, a data word reads back the value last written to it.
- R3: A command write with bit 31 set raises `dn_req_valid` on the next cycle. The request has `dn_req_write`=1, `dn_req_wdata` = {high word, low word}, and `dn_req_addr` = 0x70000 + BASE_OFS + command[IDX_W-1:0].
- R4: A command write with bit 31 clear raises a read request (`dn_req_write`=0) to the same address formula. After a response without error, the high data word holds response bits 63:32 and the low data word holds bits 31:0.
- R5: While `dn_req_valid` is high and `dn_req_ready` is low, the request stays raised with address, data and direction unchanged.
- R6: Status bit 0 (busy) is set from the cycle after a command until the cycle after its response. While busy, host writes to the data words are ignored and the data words keep their previous contents.
- R7: A response with `dn_rsp_err` high sets status bit 31. If it answers a read, it leaves the data words unchanged.
- R8: A command write while busy sets status bit 31 and launches no further request. The outstanding access completes unchanged.
- R9: Any write to the reset register clears status bit 31 and abandons a pending access. On the next cycle `dn_req_valid` is low and busy is clear.
- R10: Bit 0 of the interrupt enable register (0x20) gates the error flag onto `irq_o`.
- R11: Each accepted command produces exactly one request handshake. `dn_req_valid` falls in the cycle after `dn_req_valid`&&`dn_req_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hst_wr | input | 1 | Host write strobe, one cycle per write |
| hst_addr | input | 8 | Host byte offset |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Host read data for `hst_addr`, combinational |
| irq_o | output | 1 | Error interrupt, gated by enable |
| dn_req_valid | output | 1 | Downstream request valid |
| dn_req_ready | input | 1 | Downstream request accepted |
| dn_req_write | output | 1 | 1 = write, 0 = read |
| dn_req_addr | output | DA_W | Downstream register address |
| dn_req_wdata | output | 64 | Downstream write data |
| dn_rsp_valid | input | 1 | Downstream response strobe |
| dn_rsp_err | input | 1 | Response carries an error |
| dn_rsp_rdata | input | 64 | Response read data |

## Verification
The assertions assume that the downstream engine answers each accepted request with one single-cycle response, no earlier than the cycle after acceptance, and never without a request. They also assume that the host issues at most one write per cycle. The bench's behavioural target follows these rules. It keeps a 16-entry array of 64-bit registers, responds exactly one cycle after each handshake, and only injects errors or holds ready low when the bench asks. Abort tests hold ready low, so an abandoned request is never accepted, and no stale response can reach a later command.

// File: rtl/b64_pkg.sv
package b64_pkg;

  localparam int HADDR_W = 8;
  localparam int HOST_W  = 32;
  localparam int WIDE_W  = 2 * HOST_W;
  localparam logic [31:0] WINDOW_BASE = 32'h0007_0000;

  localparam logic [HADDR_W-1:0] OFS_HI   = 8'h00;
  localparam logic [HADDR_W-1:0] OFS_LO   = 8'h04;
  localparam logic [HADDR_W-1:0] OFS_CMD  = 8'h08;
  localparam logic [HADDR_W-1:0] OFS_RST  = 8'h18;
  localparam logic [HADDR_W-1:0] OFS_STAT = 8'h1C;
  localparam logic [HADDR_W-1:0] OFS_IEN  = 8'h20;

  localparam int CMD_DIR_BIT  = 31;
  localparam int STAT_ERR_BIT = 31;
  localparam int STAT_BSY_BIT = 0;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_REQ  = 2'd1,
    SQ_WAIT = 2'd2
  } sq_state_t;

  // Downstream address: window base + instance offset + masked index.
  function automatic logic [31:0] form_dn_addr(input logic [31:0] base_ofs,
                                               input logic [31:0] cmd,
                                               input int          idx_w);
    logic [31:0] mask;
    mask = (32'd1 << idx_w) - 32'd1;
    return WINDOW_BASE + base_ofs + (cmd & mask);
  endfunction

  function automatic logic [HOST_W-1:0] pack_status(input logic err,
                                                    input logic busy);
    logic [HOST_W-1:0] w;
    w = '0;
    w[STAT_ERR_BIT] = err;
    w[STAT_BSY_BIT] = busy;
    return w;
  endfunction

endpackage

// File: rtl/b64_hostregs.sv
module b64_hostregs
  import b64_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hst_wr,
  input  logic [HADDR_W-1:0] hst_addr,
  input  logic [HOST_W-1:0]  hst_wdata,
  output logic [HOST_W-1:0]  hst_rdata,
  input  logic               busy,
  input  logic               load_ev,
  input  logic [WIDE_W-1:0]  load_data,
  input  logic               rsp_err_ev,
  output logic [WIDE_W-1:0]  data_q,
  output logic               cmd_fire,
  output logic               cmd_clash,
  output logic               abort_ev,
  output logic               err_q,
  output logic               irq_o
);

  logic ien_q;
  logic wr_hi, wr_lo, wr_cmd, wr_ien;

  assign wr_hi     = hst_wr && (hst_addr == OFS_HI)  && !busy;
  assign wr_lo     = hst_wr && (hst_addr == OFS_LO)  && !busy;
  assign wr_cmd    = hst_wr && (hst_addr == OFS_CMD);
  assign wr_ien    = hst_wr && (hst_addr == OFS_IEN);
  assign abort_ev  = hst_wr && (hst_addr == OFS_RST);
  assign cmd_fire  = wr_cmd && !busy;
  assign cmd_clash = wr_cmd && busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q <= '0;
      err_q  <= 1'b0;
      ien_q  <= 1'b0;
    end else begin
      if (load_ev) data_q <= load_data;
      else begin
        if (wr_hi) data_q[WIDE_W-1:HOST_W] <= hst_wdata;
        if (wr_lo) data_q[HOST_W-1:0]      <= hst_wdata;
      end
      if (abort_ev)                      err_q <= 1'b0;
      else if (rsp_err_ev || cmd_clash)  err_q <= 1'b1;
      if (wr_ien) ien_q <= hst_wdata[0];
    end
  end

  always_comb begin
    case (hst_addr)
      OFS_HI:   hst_rdata = data_q[WIDE_W-1:HOST_W];
      OFS_LO:   hst_rdata = data_q[HOST_W-1:0];
      OFS_STAT: hst_rdata = pack_status(err_q, busy);
      OFS_IEN:  hst_rdata = {{(HOST_W-1){1'b0}}, ien_q};
      default:  hst_rdata = '0;
    endcase
  end

  assign irq_o = err_q && ien_q;

endmodule

// File: rtl/b64_seq.sv
module b64_seq
  import b64_pkg::*;
#(
  parameter int          DA_W     = 24,
  parameter int          IDX_W    = 4,
  parameter logic [31:0] BASE_OFS = 32'h0000_0100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_fire,
  input  logic [HOST_W-1:0] cmd_word,
  input  logic [WIDE_W-1:0] stage_data,
  input  logic              abort_ev,
  output logic              dn_req_valid,
  input  logic              dn_req_ready,
  output logic              dn_req_write,
  output logic [DA_W-1:0]   dn_req_addr,
  output logic [WIDE_W-1:0] dn_req_wdata,
  input  logic              dn_rsp_valid,
  input  logic              dn_rsp_err,
  input  logic [WIDE_W-1:0] dn_rsp_rdata,
  output logic              busy,
  output logic              load_ev,
  output logic [WIDE_W-1:0] load_data,
  output logic              rsp_err_ev
);

  sq_state_t st_q;
  logic      rsp_done;

  assign rsp_done   = (st_q == SQ_WAIT) && dn_rsp_valid && !abort_ev;
  assign load_ev    = rsp_done && !dn_req_write && !dn_rsp_err;
  assign load_data  = dn_rsp_rdata;
  assign rsp_err_ev = rsp_done && dn_rsp_err;
  assign busy       = (st_q != SQ_IDLE);
  assign dn_req_valid = (st_q == SQ_REQ);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q         <= SQ_IDLE;
      dn_req_write <= 1'b0;
      dn_req_addr  <= '0;
      dn_req_wdata <= '0;
    end else if (abort_ev) begin
      st_q <= SQ_IDLE;
    end else begin
      case (st_q)
        SQ_IDLE: if (cmd_fire) begin
          st_q         <= SQ_REQ;
          dn_req_write <= cmd_word[CMD_DIR_BIT];
          dn_req_addr  <= DA_W'(form_dn_addr(BASE_OFS, cmd_word, IDX_W));
          dn_req_wdata <= stage_data;
        end
        SQ_REQ:  if (dn_req_ready) st_q <= SQ_WAIT;
        SQ_WAIT: if (dn_rsp_valid) st_q <= SQ_IDLE;
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/b64_bridge.sv
module b64_bridge
  import b64_pkg::*;
#(
  parameter int          DA_W     = 24,
  parameter int          IDX_W    = 4,
  parameter logic [31:0] BASE_OFS = 32'h0000_0100
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hst_wr,
  input  logic [HADDR_W-1:0] hst_addr,
  input  logic [HOST_W-1:0]  hst_wdata,
  output logic [HOST_W-1:0]  hst_rdata,
  output logic               irq_o,
  output logic               dn_req_valid,
  input  logic               dn_req_ready,
  output logic               dn_req_write,
  output logic [DA_W-1:0]    dn_req_addr,
  output logic [WIDE_W-1:0]  dn_req_wdata,
  input  logic               dn_rsp_valid,
  input  logic               dn_rsp_err,
  input  logic [WIDE_W-1:0]  dn_rsp_rdata
);

  // Named internal events, observed by the bound checker.
  logic              busy;
  logic              load_ev;
  logic [WIDE_W-1:0] load_data;
  logic              rsp_err_ev;
  logic [WIDE_W-1:0] data_q;
  logic              cmd_fire;
  logic              cmd_clash;
  logic              abort_ev;
  logic              err_q;

  b64_hostregs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .hst_wr     (hst_wr),
    .hst_addr   (hst_addr),
    .hst_wdata  (hst_wdata),
    .hst_rdata  (hst_rdata),
    .busy       (busy),
    .load_ev    (load_ev),
    .load_data  (load_data),
    .rsp_err_ev (rsp_err_ev),
    .data_q     (data_q),
    .cmd_fire   (cmd_fire),
    .cmd_clash  (cmd_clash),
    .abort_ev   (abort_ev),
    .err_q      (err_q),
    .irq_o      (irq_o)
  );

  b64_seq #(
    .DA_W     (DA_W),
    .IDX_W    (IDX_W),
    .BASE_OFS (BASE_OFS)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_fire     (cmd_fire),
    .cmd_word     (hst_wdata),
    .stage_data   (data_q),
    .abort_ev     (abort_ev),
    .dn_req_valid (dn_req_valid),
    .dn_req_ready (dn_req_ready),
    .dn_req_write (dn_req_write),
    .dn_req_addr  (dn_req_addr),
    .dn_req_wdata (dn_req_wdata),
    .dn_rsp_valid (dn_rsp_valid),
    .dn_rsp_err   (dn_rsp_err),
    .dn_rsp_rdata (dn_rsp_rdata),
    .busy         (busy),
    .load_ev      (load_ev),
    .load_data    (load_data),
    .rsp_err_ev   (rsp_err_ev)
  );

endmodule

// File: rtl/b64_bridge_chk.sv
module b64_bridge_chk #(
  parameter int DA_W = 24
) (
  input logic            clk,
  input logic            rst_n,
  input logic            dn_req_valid,
  input logic            dn_req_ready,
  input logic            dn_req_write,
  input logic [DA_W-1:0] dn_req_addr,
  input logic [63:0]     dn_req_wdata,
  input logic            busy,
  input logic            err_q,
  input logic            abort_ev,
  input logic            cmd_clash,
  input logic            rsp_err_ev
);

  assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_req_valid && !dn_req_ready && !abort_ev) |=>
      (dn_req_valid && $stable(dn_req_addr) && $stable(dn_req_wdata) && $stable(dn_req_write)));

  assert_one_handshake_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_req_valid && dn_req_ready) |=> !dn_req_valid);

  assert_busy_cover_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req_valid |-> busy);

  assert_err_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err_ev |=> err_q);

  assert_clash_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_clash && !abort_ev) |=> (err_q && !$rose(dn_req_valid)));

  assert_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
    abort_ev |=> (!dn_req_valid && !busy && !err_q));

endmodule

bind b64_bridge b64_bridge_chk #(.DA_W(DA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .dn_req_valid (dn_req_valid),
  .dn_req_ready (dn_req_ready),
  .dn_req_write (dn_req_write),
  .dn_req_addr  (dn_req_addr),
  .dn_req_wdata (dn_req_wdata),
  .busy         (busy),
  .err_q        (err_q),
  .abort_ev     (abort_ev),
  .cmd_clash    (cmd_clash),
  .rsp_err_ev   (rsp_err_ev)
);

// File: tb/b64_bridge_tb.sv
module b64_bridge_tb;

  localparam int          CLK_P    = 10;
  localparam int          DA_W     = 24;
  localparam int          IDX_W    = 4;
  localparam int          NREG     = 1 << IDX_W;
  localparam logic [31:0] BASE_OFS = 32'h0000_0100;
  localparam logic [DA_W-1:0] EXP_BASE = DA_W'(32'h0007_0000 + BASE_OFS);

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            hst_wr = 1'b0;
  logic [7:0]      hst_addr = 8'h00;
  logic [31:0]     hst_wdata = 32'h0;
  logic [31:0]     hst_rdata;
  logic            irq_o;
  logic            dn_req_valid;
  logic            dn_req_ready = 1'b1;
  logic            dn_req_write;
  logic [DA_W-1:0] dn_req_addr;
  logic [63:0]     dn_req_wdata;
  logic            dn_rsp_valid;
  logic            dn_rsp_err;
  logic [63:0]     dn_rsp_rdata;

  logic            inj_err = 1'b0;
  int              errors = 0;
  int              checks = 0;
  bit              done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  b64_bridge #(.DA_W(DA_W), .IDX_W(IDX_W), .BASE_OFS(BASE_OFS)) u_dut (
    .clk(clk), .rst_n(rst_n), .hst_wr(hst_wr), .hst_addr(hst_addr),
    .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .irq_o(irq_o),
    .dn_req_valid(dn_req_valid), .dn_req_ready(dn_req_ready),
    .dn_req_write(dn_req_write), .dn_req_addr(dn_req_addr),
    .dn_req_wdata(dn_req_wdata), .dn_rsp_valid(dn_rsp_valid),
    .dn_rsp_err(dn_rsp_err), .dn_rsp_rdata(dn_rsp_rdata)
  );

  // Behavioural downstream target: responds one cycle after each handshake.
  logic [63:0]     mem [NREG];
  int              acc_cnt;
  logic [DA_W-1:0] last_addr;
  logic            last_write;
  logic [63:0]     last_wdata;
  logic [DA_W-1:0] req_off;
  assign req_off = dn_req_addr - EXP_BASE;

  always @(posedge clk) begin
    if (!rst_n) begin
      dn_rsp_valid <= 1'b0;
      dn_rsp_err   <= 1'b0;
      dn_rsp_rdata <= '0;
      acc_cnt      <= 0;
      last_addr    <= '0;
      last_write   <= 1'b0;
      last_wdata   <= '0;
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
    end else begin
      dn_rsp_valid <= 1'b0;
      if (dn_req_valid && dn_req_ready) begin
        acc_cnt      <= acc_cnt + 1;
        last_addr    <= dn_req_addr;
        last_write   <= dn_req_write;
        last_wdata   <= dn_req_wdata;
        dn_rsp_valid <= 1'b1;
        dn_rsp_err   <= inj_err;
        dn_rsp_rdata <= mem[req_off[IDX_W-1:0]];
        if (dn_req_write && !inj_err) mem[req_off[IDX_W-1:0]] <= dn_req_wdata;
      end
    end
  end

  function automatic logic [63:0] pat(input int i);
    return 64'h0123_4567_89AB_CDEF ^ (64'(i + 1) * 64'h9E37_79B9_7F4A_7C15);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Tasks start and end just after a falling edge.
  task automatic hwr(input logic [7:0] a, input logic [31:0] d);
    hst_wr = 1'b1; hst_addr = a; hst_wdata = d;
    @(posedge clk); @(negedge clk);
    hst_wr = 1'b0;
  endtask

  task automatic hrd(input logic [7:0] a, output logic [31:0] d);
    hst_addr = a; #1; d = hst_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int k = 0; k < 64; k++) begin
      hrd(8'h1C, s);
      if (!s[0]) break;
      @(negedge clk);
    end
  endtask

  initial begin
    logic [31:0] r, r2;
    logic [DA_W-1:0] a0;
    int base_cnt;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    hrd(8'h1C, r); chk(r == 0, "R1", "status", 64'(r), 0);
    hrd(8'h00, r); chk(r == 0, "R1", "data hi", 64'(r), 0);
    hrd(8'h04, r); chk(r == 0, "R1", "data lo", 64'(r), 0);
    hrd(8'h20, r); chk(r == 0, "R1", "irq enable", 64'(r), 0);
    chk(!dn_req_valid && !irq_o, "R1", "req/irq", {62'd0, dn_req_valid, irq_o}, 0);

    // R2: offsets and idle readback
    hwr(8'h00, 32'hDEAD_BEEF); hwr(8'h04, 32'h1357_9BDF);
    hrd(8'h00, r); chk(r == 32'hDEAD_BEEF, "R2", "hi readback", 64'(r), 64'hDEAD_BEEF);
    hrd(8'h04, r); chk(r == 32'h1357_9BDF, "R2", "lo readback", 64'(r), 64'h1357_9BDF);
    hrd(8'h08, r); chk(r == 0, "R2", "cmd reads zero", 64'(r), 0);
    hrd(8'h3C, r); chk(r == 0, "R2", "unmapped reads zero", 64'(r), 0);

    // R3/R11: write sweep over every index
    for (int i = 0; i < NREG; i++) begin
      base_cnt = acc_cnt;
      hwr(8'h00, pat(i)[63:32]); hwr(8'h04, pat(i)[31:0]);
      hwr(8'h08, 32'h8000_0000 | 32'(i) | 32'h0000_0F00);
      wait_idle(); @(negedge clk);
      chk(last_write == 1'b1, "R3", "direction", 64'(last_write), 1);
      chk(last_addr == EXP_BASE + DA_W'(i), "R3", "address", 64'(last_addr), 64'(EXP_BASE + DA_W'(i)));
      chk(last_wdata == pat(i), "R3", "wdata", last_wdata, pat(i));
      chk(acc_cnt == base_cnt + 1, "R11", "one handshake", 64'(acc_cnt - base_cnt), 1);
    end

    // R4: read sweep, scrambling the data words first
    for (int i = NREG - 1; i >= 0; i--) begin
      hwr(8'h00, 32'h5A5A_5A5A); hwr(8'h04, 32'hA5A5_A5A5);
      hwr(8'h08, 32'(i));
      wait_idle();
      chk(last_write == 1'b0, "R4", "direction", 64'(last_write), 0);
      hrd(8'h00, r); chk(r == pat(i)[63:32], "R4", "hi", 64'(r), 64'(pat(i)[63:32]));
      hrd(8'h04, r); chk(r == pat(i)[31:0], "R4", "lo", 64'(r), 64'(pat(i)[31:0]));
    end

    // R5/R6: stalled write
    base_cnt = acc_cnt;
    dn_req_ready = 1'b0;
    hwr(8'h00, 32'hCAFE_0001); hwr(8'h04, 32'hCAFE_0002);
    hwr(8'h08, 32'h8000_0003);
    a0 = dn_req_addr;
    for (int k = 0; k < 4; k++) begin
      chk(dn_req_valid && dn_req_addr == a0 && dn_req_write, "R5", "held request",
          64'(dn_req_addr), 64'(a0));
      hrd(8'h1C, r); chk(r[0], "R6", "busy", 64'(r), 1);
      hwr(8'h00, 32'h0BAD_0BAD);
      hrd(8'h00, r); chk(r == 32'hCAFE_0001, "R6", "data kept", 64'(r), 64'hCAFE_0001);
    end
    dn_req_ready = 1'b1;
    wait_idle();
    hrd(8'h1C, r); chk(r == 0, "R6", "idle after response", 64'(r), 0);
    chk(last_wdata == 64'hCAFE_0001_CAFE_0002, "R5", "stalled wdata", last_wdata, 64'hCAFE_0001_CAFE_0002);
    chk(acc_cnt == base_cnt + 1, "R11", "one handshake stalled", 64'(acc_cnt - base_cnt), 1);

    // R7/R10: error response on a read
    inj_err = 1'b1;
    hwr(8'h08, 32'h0000_0005);
    wait_idle();
    inj_err = 1'b0;
    hrd(8'h1C, r); chk(r == 32'h8000_0000, "R7", "error flag", 64'(r), 64'h8000_0000);
    hrd(8'h00, r); chk(r == 32'hCAFE_0001, "R7", "data hi unchanged", 64'(r), 64'hCAFE_0001);
    hrd(8'h04, r2); chk(r2 == 32'hCAFE_0002, "R7", "data lo unchanged", 64'(r2), 64'hCAFE_0002);
    chk(!irq_o, "R10", "irq masked", 64'(irq_o), 0);
    hwr(8'h20, 32'h1);
    chk(irq_o, "R10", "irq enabled", 64'(irq_o), 1);
    hwr(8'h18, 32'h0);
    hrd(8'h1C, r); chk(r == 0, "R9", "error cleared", 64'(r), 0);
    chk(!irq_o, "R10", "irq follows clear", 64'(irq_o), 0);
    hwr(8'h20, 32'h0);

    // R8: command while busy
    base_cnt = acc_cnt;
    dn_req_ready = 1'b0;
    hwr(8'h08, 32'h0000_0002);
    hwr(8'h08, 32'h8000_0007);
    hrd(8'h1C, r); chk(r == 32'h8000_0001, "R8", "clash error+busy", 64'(r), 64'h8000_0001);
    dn_req_ready = 1'b1;
    wait_idle(); repeat (3) @(negedge clk);
    chk(acc_cnt == base_cnt + 1, "R8", "no second request", 64'(acc_cnt - base_cnt), 1);
    chk(last_write == 1'b0 && last_addr == EXP_BASE + DA_W'(2), "R8", "first command kept",
        64'(last_addr), 64'(EXP_BASE + DA_W'(2)));
    hrd(8'h00, r); chk(r == pat(2)[63:32], "R8", "read completed", 64'(r), 64'(pat(2)[63:32]));
    hwr(8'h18, 32'h0);

    // R9: abort a pending request
    base_cnt = acc_cnt;
    dn_req_ready = 1'b0;
    hwr(8'h08, 32'h8000_0009);
    chk(dn_req_valid, "R9", "request raised", 64'(dn_req_valid), 1);
    hwr(8'h18, 32'h0);
    chk(!dn_req_valid, "R9", "request dropped", 64'(dn_req_valid), 0);
    hrd(8'h1C, r); chk(r == 0, "R9", "status after abort", 64'(r), 0);
    dn_req_ready = 1'b1;
    repeat (4) @(negedge clk);
    chk(acc_cnt == base_cnt, "R9", "no handshake", 64'(acc_cnt - base_cnt), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule